// File: doc/BRIEF.md
# Dual-Drive IDE Programmed-I/O Cycle Timer

This block produces the host-side strobe timing for programmed-I/O transfers on an IDE channel that carries two drives. A transfer is launched by a one-clock start request together with a direction flag and a drive number. The block then counts out three whole-clock phases. First comes address setup, with the address marked valid and no strobe. Next is the active data pulse, during which the read or the write strobe is high. Last is recovery, with both the address qualifier and the strobe low. Busy is high for the whole transfer, and done pulses once when it ends.

The phase lengths come from small timing registers that software loads through a simple write port. Two banks of cycle-timing registers exist, and each bank has one register for reads and one for writes. Each of these registers packs a data-pulse count and a recovery count in offset form. The address-setup count sits in a separate miscellaneous register that serves both drives, so software loads it with the larger of the two drives' needs. A control bit decides whether drive 1 uses its own bank or shares the first one. After reset every field holds its slowest encoding, so an unconfigured drive still sees safe timing. Converting nanoseconds to clocks is left to software.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, busy, done, address-valid and both strobes are low. Both drives use bank A. Every transfer then runs 4 setup clocks, 16 data clocks and 17 recovery clocks until software reprograms the block.
- R2: A transfer runs setup, then data, then recovery, in that order and with no gaps. Address-valid is high exactly during setup and data, and a strobe is high only during data.
- R3: The data phase lasts (field+1) clocks, from 1 to 16, where the field is bits 7:4 of the selected cycle-timing register.
- R4: The recovery phase lasts (field+2) clocks, from 2 to 17, where the field is bits 3:0 of the selected cycle-timing register.
- R5: The setup phase lasts (field+1) clocks, from 1 to 4, where the field is bits 5:4 of the miscellaneous register at address 4. Bits 7:6 and 3:0 of that register are ignored, and the same setup count applies to both drives.
- R6: The cycle-timing registers sit at address 0 (bank A read), address 1 (bank A write), address 2 (bank B read) and address 3 (bank B write). A read transfer (flag 0) uses the read register and raises only the read strobe. A write transfer (flag 1) uses the write register and raises only the write strobe.
- R7: Bit 2 of the control register at address 5 is the bank-split bit, and it resets to 0. When the bit is 1 (for example after writing 0x85), drive 0 uses bank A and drive 1 uses bank B. When the bit is 0, both drives use bank A.
- R8: Busy rises on the clock after start is accepted and stays high until the last recovery clock. Done is then high for exactly one clock, with busy low.
- R9: A start request that arrives while busy is ignored. It neither lengthens nor restarts the current transfer, and it does not launch a new one afterwards.
- R10: The timing and direction of a transfer are fixed when it starts. A register write made during the transfer does not change it, but it does apply to the next transfer.
- R11: Writes to addresses 6 and 7 change no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock transfer request |
| rw_write_i | input | 1 | Transfer direction: 0 read, 1 write |
| drive_sel_i | input | 1 | Target drive number |
| cfg_we_i | input | 1 | Timing register write enable |
| cfg_addr_i | input | 3 | Timing register address |
| cfg_wdata_i | input | 8 | Timing register write data |
| addr_valid_o | output | 1 | Address qualifier, high in setup and data |
| rd_strobe_o | output | 1 | Read strobe, high during a read data phase |
| wr_strobe_o | output | 1 | Write strobe, high during a write data phase |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock end-of-transfer pulse |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that start is only a request: it may arrive in any cycle, including while a transfer is in progress. Nothing is assumed about when registers are written, except that the bench never writes on the same edge as an accepted start. The stimulus keeps to that by issuing register writes either between transfers or in the second cycle of a transfer. It raises extra start requests only while busy is high and never on the clock that carries done.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

    localparam int NUM_BANKS = 2;
    localparam int PULSE_W   = 4;
    localparam int REC_W     = 4;
    localparam int SETUP_W   = 2;
    localparam int CFG_AW    = 3;
    localparam int CFG_DW    = 8;
    localparam int SLOT_CNT  = 2 * NUM_BANKS;
    localparam int SLOT_W    = $clog2(SLOT_CNT);
    localparam int CNT_W     = $clog2((1 << REC_W) + 2);

    localparam logic [CFG_AW-1:0] ADDR_MISC = CFG_AW'(SLOT_CNT);
    localparam logic [CFG_AW-1:0] ADDR_CTRL = CFG_AW'(SLOT_CNT + 1);

    localparam int MISC_SETUP_LSB = 4;
    localparam int CTRL_SPLIT_BIT = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_DATA,
        PH_RECOV
    } phase_t;

    // Packed layout matches the register: pulse in the high nibble.
    typedef struct packed {
        logic [PULSE_W-1:0] pulse_enc;
        logic [REC_W-1:0]   rec_enc;
    } cyc_timing_t;

    typedef struct packed {
        logic [SETUP_W-1:0] setup_enc;
        cyc_timing_t        cyc;
    } xfer_timing_t;

    // Recovery is stored as count-2; the down counter needs count-1.
    function automatic logic [CNT_W-1:0] rec_load(input logic [REC_W-1:0] enc);
        return CNT_W'(enc) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [CFG_DW-1:0] cfg_wdata_i,
    input  logic              drive_sel_i,
    input  logic              rw_write_i,
    output xfer_timing_t      timing_o
);

    cyc_timing_t        slot_tab [SLOT_CNT];
    logic [SETUP_W-1:0] setup_q;
    logic               split_q;
    logic               bank_sel;
    logic [SLOT_W-1:0]  slot_sel;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar d = 0; d < 2; d++) begin : g_dir
            cyc_timing_t slot_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q <= '1;
                end else if (cfg_we_i && cfg_addr_i == CFG_AW'(2 * b + d)) begin
                    slot_q <= cyc_timing_t'(cfg_wdata_i);
                end
            end
            assign slot_tab[2 * b + d] = slot_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= '1;
            split_q <= 1'b0;
        end else if (cfg_we_i) begin
            if (cfg_addr_i == ADDR_MISC) begin
                setup_q <= cfg_wdata_i[MISC_SETUP_LSB +: SETUP_W];
            end
            if (cfg_addr_i == ADDR_CTRL) begin
                split_q <= cfg_wdata_i[CTRL_SPLIT_BIT];
            end
        end
    end

    always_comb begin
        bank_sel = split_q ? drive_sel_i : 1'b0;
        slot_sel = {bank_sel, rw_write_i};
        timing_o.setup_enc = setup_q;
        timing_o.cyc       = slot_tab[slot_sel];
    end

    // With the split bit clear, drive 1 must read bank A registers.
    AST_SHARED_BANK: assert property (@(posedge clk) disable iff (rst)
        (!split_q && drive_sel_i) |-> (timing_o.cyc == slot_tab[{1'b0, rw_write_i}])); // R7

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_timer_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         rw_write_i,
    input  xfer_timing_t timing_i,
    output phase_t       phase_o,
    output logic         xfer_write_o,
    output logic         done_o
);

    phase_t            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    cyc_timing_t       lat_q;
    logic              wr_q;
    logic              done_q;
    logic              cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            lat_q   <= '1;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= CNT_W'(timing_i.setup_enc);
                        lat_q   <= timing_i.cyc;
                        wr_q    <= rw_write_i;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase_q <= PH_DATA;
                        cnt_q   <= CNT_W'(lat_q.pulse_enc);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt_zero) begin
                        phase_q <= PH_RECOV;
                        cnt_q   <= rec_load(lat_q.rec_enc);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (cnt_zero) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o      = phase_q;
    assign xfer_write_o = wr_q;
    assign done_o       = done_q;

    AST_SETUP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SETUP) |-> (cnt_q < CNT_W'(1 << SETUP_W))); // R5

    AST_RECOV_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RECOV) |-> (cnt_q <= CNT_W'(1 << REC_W))); // R4

    AST_SETUP_TO_DATA: assert property (@(posedge clk) disable iff (rst)
        ($past(phase_q) == PH_SETUP && phase_q != PH_SETUP) |-> (phase_q == PH_DATA)); // R2

    AST_DATA_TO_RECOV: assert property (@(posedge clk) disable iff (rst)
        ($past(phase_q) == PH_DATA && phase_q != PH_DATA) |-> (phase_q == PH_RECOV)); // R2

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start_i && (phase_q == PH_DATA || phase_q == PH_RECOV)) |=> (phase_q != PH_SETUP)); // R9

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(wr_q)); // R10

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
    import pio_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rw_write_i,
    input  logic              drive_sel_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [CFG_DW-1:0] cfg_wdata_i,
    output logic              addr_valid_o,
    output logic              rd_strobe_o,
    output logic              wr_strobe_o,
    output logic              busy_o,
    output logic              done_o
);

    xfer_timing_t sel_timing;
    phase_t       phase;
    logic         xfer_write;

    pio_timing_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .drive_sel_i (drive_sel_i),
        .rw_write_i  (rw_write_i),
        .timing_o    (sel_timing)
    );

    pio_phase_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .rw_write_i   (rw_write_i),
        .timing_i     (sel_timing),
        .phase_o      (phase),
        .xfer_write_o (xfer_write),
        .done_o       (done_o)
    );

    assign busy_o       = (phase != PH_IDLE);
    assign addr_valid_o = (phase == PH_SETUP) || (phase == PH_DATA);
    assign rd_strobe_o  = (phase == PH_DATA) && !xfer_write;
    assign wr_strobe_o  = (phase == PH_DATA) && xfer_write;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_strobe_o, wr_strobe_o})); // R6

    AST_STROBE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe_o || wr_strobe_o) |-> (addr_valid_o && busy_o)); // R2

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

endmodule

// File: tb/pio_cycle_timer_bench.sv
`timescale 1ns/1ps
module pio_cycle_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       rw_write_i = 1'b0;
    logic       drive_sel_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [2:0] cfg_addr_i = '0;
    logic [7:0] cfg_wdata_i = '0;
    logic       addr_valid_o, rd_strobe_o, wr_strobe_o, busy_o, done_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] m_cyc [4];
    logic [1:0] m_setup;
    logic       m_split;

    always #2.5 clk = ~clk;

    pio_cycle_timer u_pio_cycle_timer (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .rw_write_i   (rw_write_i),
        .drive_sel_i  (drive_sel_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_addr_i   (cfg_addr_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .addr_valid_o (addr_valid_o),
        .rd_strobe_o  (rd_strobe_o),
        .wr_strobe_o  (wr_strobe_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model_apply(input logic [2:0] a, input logic [7:0] d);
        if (a < 3'd4)       m_cyc[a] = d;
        else if (a == 3'd4) m_setup = d[5:4];
        else if (a == 3'd5) m_split = d[2];
    endfunction

    function automatic int exp_setup();
        return int'(m_setup) + 1;
    endfunction

    function automatic int slot_of(input bit rw, input bit drv);
        return ((m_split ? int'(drv) : 0) * 2) + int'(rw);
    endfunction

    function automatic int exp_data(input bit rw, input bit drv);
        return int'(m_cyc[slot_of(rw, drv)][7:4]) + 1;
    endfunction

    function automatic int exp_rec(input bit rw, input bit drv);
        return int'(m_cyc[slot_of(rw, drv)][3:0]) + 2;
    endfunction

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
        model_apply(a, d);
    endtask

    // Runs one transfer; optional extra start while busy and optional mid-transfer write.
    task automatic run_xfer(input bit rw, input bit drv, input bit inject,
                            input bit mid_we, input logic [2:0] mid_a, input logic [7:0] mid_d,
                            input string tag);
        int e_s, e_d, e_r;
        int n_s = 0, n_d = 0, n_r = 0;
        int stage = 0;
        bit order_ok = 1'b1;
        bit strobe_ok = 1'b1;
        bit saw_done = 1'b0;
        bit done_busy = 1'b0;
        e_s = exp_setup();
        e_d = exp_data(rw, drv);
        e_r = exp_rec(rw, drv);
        @(negedge clk);
        start_i = 1'b1; rw_write_i = rw; drive_sel_i = drv;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 80; i++) begin
            if (done_o) begin
                saw_done = 1'b1;
                done_busy = busy_o;
                break;
            end
            if (!busy_o) order_ok = 1'b0;
            if (rd_strobe_o || wr_strobe_o) begin
                n_d++;
                if (stage > 1) order_ok = 1'b0;
                stage = 1;
                if (!addr_valid_o) order_ok = 1'b0;
                if (rd_strobe_o != !rw || wr_strobe_o != rw) strobe_ok = 1'b0;
            end else if (addr_valid_o) begin
                n_s++;
                if (stage > 0) order_ok = 1'b0;
            end else begin
                n_r++;
                stage = 2;
            end
            if (i == 1) begin
                if (inject) begin
                    start_i = 1'b1; rw_write_i = !rw; drive_sel_i = !drv;
                end
                if (mid_we) begin
                    cfg_we_i = 1'b1; cfg_addr_i = mid_a; cfg_wdata_i = mid_d;
                end
            end else if (i == 2) begin
                start_i = 1'b0;
                cfg_we_i = 1'b0;
            end
            @(negedge clk);
        end
        if (mid_we) model_apply(mid_a, mid_d);
        chk(n_s == e_s, {tag, " R5 setup clocks"}, n_s, e_s);
        chk(n_d == e_d, {tag, " R3 data clocks"}, n_d, e_d);
        chk(n_r == e_r, {tag, " R4 recovery clocks"}, n_r, e_r);
        chk(strobe_ok, {tag, " R6 strobe matches direction"}, int'(strobe_ok), 1);
        chk(order_ok, {tag, " R2 phase order and qualifiers"}, int'(order_ok), 1);
        chk(saw_done && !done_busy, {tag, " R8 done with busy low"}, int'(saw_done && !done_busy), 1);
        @(negedge clk);
        chk(!done_o && !busy_o, {tag, " R8 R9 no pulse or restart after done"},
            int'(done_o || busy_o), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < 4; k++) m_cyc[k] = 8'hFF;
        m_setup = 2'b11;
        m_split = 1'b0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state at the ports
        chk({busy_o, done_o, addr_valid_o, rd_strobe_o, wr_strobe_o} == 5'b0,
            "R1 idle outputs after reset",
            int'({busy_o, done_o, addr_valid_o, rd_strobe_o, wr_strobe_o}), 0);

        // R1: slowest defaults for every direction and drive
        run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, "R1 default rd d0");
        run_xfer(1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R1 default wr d1");

        // Minimum encodings: 1 / 1 / 2 clocks
        cfg_write(3'd0, 8'h00);
        cfg_write(3'd4, 8'h00);
        run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, "R3 R4 minimum");

        // R6: separate read and write registers in bank A
        cfg_write(3'd1, 8'h52);
        run_xfer(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, "R6 write reg");
        run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, "R6 read reg");

        // R7: split clear means drive 1 still uses bank A
        cfg_write(3'd2, 8'hA7);
        cfg_write(3'd3, 8'h3C);
        run_xfer(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R7 shared bank");
        cfg_write(3'd5, 8'h85);
        run_xfer(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R7 bank B read");
        run_xfer(1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R7 bank B write");
        run_xfer(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, "R7 drive0 bank A");

        // R5: only bits 5:4 of the misc register count; shared by both drives
        cfg_write(3'd4, 8'hCF);
        run_xfer(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R5 misc extra bits");
        cfg_write(3'd4, 8'h20);
        run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, "R5 setup drive0");
        run_xfer(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R5 setup drive1");

        // R11: unmapped addresses change nothing
        cfg_write(3'd6, 8'h00);
        cfg_write(3'd7, 8'hFF);
        run_xfer(1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R11 unmapped writes");

        // R9: start while busy ignored
        run_xfer(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 8'h00, "R9 start while busy");

        // R10: mid-transfer writes affect only the next transfer
        run_xfer(1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 8'h11, "R10 mid write cyc");
        run_xfer(1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R10 next uses new cyc");
        run_xfer(1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 8'h30, "R10 mid write setup");
        run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, "R10 next uses new setup");

        // Random mix
        for (int it = 0; it < 40; it++) begin
            logic [2:0] a;
            a = 3'($urandom_range(0, 7));
            cfg_write(a, 8'($urandom));
            run_xfer(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     3'($urandom_range(0, 7)), 8'($urandom), "random R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule